// File: doc/BRIEF.md
# Crosstalk-avoiding bus segment transmitter

This block is the sending end of a long, wide on-chip bus that carries instruction words from memory towards a prefetch unit. Each accepted word is cut into four 32-bit segments. Every cycle the block compares each candidate segment with the value that the target channel drove in the previous cycle. It puts the segment on that channel only if no wire of the channel would switch into one of the two severe coupling classes. A channel that cannot take a segment carries an idle code. A flag wire next to each channel tells the receiver whether the channel holds data or is idle.

Segments leave in word order. Within a cycle the channels are scanned from the top lane down. The oldest unsent segment is offered to each lane in turn, and a lane that refuses it is filled with idle. Segments that are still unsent carry over to the next cycle, where the scan starts again from the top lane. The receiver rebuilds the word by concatenating, in lane order, the lanes whose flag is set.

The upstream side is valid/ready. A word transfers on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high when nothing is pending, or when every remaining segment is placed in the current cycle. While it is low, `in_valid` and `in_data` are ignored, and the source must hold its word until the transfer. The bus side has no handshake.

Top module: `xtb_tx`

## Requirements
- R1: While reset is asserted, `bus_out` is all zero and `in_ready` is high.
- R2: Segment 0 of a word is `in_data[127:96]` and segment 3 is `in_data[31:0]`. The lanes are placed as follows:
  - lane 0 uses `bus_out[134:103]`, with its flag at bit 102 and a zero shield at bit 101;
  - lane 1 uses `[100:69]`, with its flag at 68 and a shield at 67;
  - lane 2 uses `[66:35]`, with its flag at 34 and a shield at 33;
  - lane 3 uses `[32:1]`, with its flag at bit 0.
- R3: A lane's flag is 1 when the lane carries a segment and 0 when it is idle. The two wires between lanes therefore read "10" for data and "00" for idle.
- R4: A lane with no segment offered to it in a cycle keeps its 32 data wires unchanged and clears its flag.
- R5: A segment is refused by a lane if any wire would toggle while one of these holds:
  - both neighbours toggle in the opposite direction;
  - one neighbour toggles in the opposite direction and the other is static.

  A wire at a lane edge counts its missing neighbour as static. Milder transitions are accepted: 0x0000000C to 0x00000030 is accepted, and 0x00000004 to 0x00000008 is refused.
- R6: A lane that refuses a segment carries an idle code with flag 0. Its even-index data bits hold their previous value. Its odd-index data bits take the odd-index bits of the refused segment.
- R7: Each cycle the oldest unsent segment is offered to lanes 0 to 3 in turn. An accepted segment advances the offer to the next segment, and a refusal keeps the same segment for the next lane. Segments still unsent are offered from lane 0 in the following cycle.
- R8: If a cycle with a pending segment sends no segment at all, the following cycle sends at least one.
- R9: Transfer and timing:
  - `in_ready` is high exactly when no segment is pending, or when all remaining segments are placed in the current cycle;
  - a word transfers on `in_valid && in_ready`, and its first bus cycle follows the transfer cycle;
  - when `in_ready` is low, the input word is not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 128 | Upstream word, segment 0 in the top 32 bits |
| bus_out | output | 135 | Bus wires: four lanes, their flags and shields |

## Verification
The assertions take for granted that reset is low from time zero and that `in_valid` is low while reset is held, so the first comparison with the previous bus value starts from all zeros. The coupling check in the checker uses its own copy of the previous bus value and does not rely on the design's lane registers. The bench drives inputs one time unit after each rising edge and holds each word until it transfers. Each scenario starts from a fresh reset, so the previous lane values that decide whether a segment is accepted or refused are known exactly.

// File: rtl/xtb_pkg.sv
package xtb_pkg;

  // What a lane carries in one cycle
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,  // nothing offered: wires hold, flag low
    SLOT_DATA = 2'd1,  // segment placed, flag high
    SLOT_HOLD = 2'd2   // segment refused: staged idle code, flag low
  } slot_kind_e;

  // Lowest data wire of lane c; lanes are laid from the top of the bus
  function automatic int lane_lsb(input int bus_w, input int seg_w, input int c);
    return bus_w - (c + 1) * seg_w - 2 * c;
  endfunction

endpackage

// File: rtl/xtb_severity.sv
// Flags a lane transition in which some wire toggles against both
// neighbours, or against one neighbour while the other stays static.
module xtb_severity #(
  parameter int W = 32
) (
  input  logic [W-1:0] prv,
  input  logic [W-1:0] nxt,
  output logic         severe
);

  logic [W-1:0] tog;
  logic [W-1:0] lo_opp, lo_st, hi_opp, hi_st, bad;

  assign tog = prv ^ nxt;

  for (genvar j = 0; j < W; j++) begin : g_bit
    if (j == 0) begin : g_lo_edge
      assign lo_opp[j] = 1'b0;
      assign lo_st[j]  = 1'b1;
    end else begin : g_lo
      // both toggle and started from different levels -> opposite
      assign lo_opp[j] = tog[j-1] & (prv[j-1] ^ prv[j]);
      assign lo_st[j]  = ~tog[j-1];
    end
    if (j == W - 1) begin : g_hi_edge
      assign hi_opp[j] = 1'b0;
      assign hi_st[j]  = 1'b1;
    end else begin : g_hi
      assign hi_opp[j] = tog[j+1] & (prv[j+1] ^ prv[j]);
      assign hi_st[j]  = ~tog[j+1];
    end
    assign bad[j] = tog[j] &
                    ((lo_opp[j] & (hi_opp[j] | hi_st[j])) | (lo_st[j] & hi_opp[j]));
  end

  assign severe = |bad;

endmodule

// File: rtl/xtb_slot_alloc.sv
// Scans the lanes in order and offers the oldest unsent segment to each.
module xtb_slot_alloc
  import xtb_pkg::*;
#(
  parameter int SEG_W = 32,
  parameter int N_CH  = 4,
  localparam int HW   = $clog2(N_CH + 1)
) (
  input  logic [N_CH-1:0][SEG_W-1:0] seg_q,
  input  logic [N_CH-1:0][SEG_W-1:0] prev_ch,
  input  logic [HW-1:0]              head,
  output logic [N_CH-1:0][SEG_W-1:0] ch_nxt,
  output logic [N_CH-1:0]            flag_nxt,
  output logic [HW-1:0]              placed
);

  logic [SEG_W-1:0] odd_m;
  for (genvar b = 0; b < SEG_W; b++) begin : g_odd
    assign odd_m[b] = (b % 2 == 1);
  end

  // k[c]: segments already placed on lanes above lane c
  logic [HW-1:0] k [N_CH+1];
  assign k[0] = '0;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [HW:0]      idx;
    logic             has, sev, take;
    logic [SEG_W-1:0] cand, val;
    logic             flg;
    slot_kind_e       kind;

    assign idx = {1'b0, head} + {1'b0, k[c]};
    assign has = idx < (HW+1)'(N_CH);

    always_comb begin
      cand = '0;
      for (int s = 0; s < N_CH; s++) begin
        if (idx == (HW+1)'(s)) cand = seg_q[s];
      end
    end

    xtb_severity #(.W(SEG_W)) u_sev (
      .prv    (prev_ch[c]),
      .nxt    (cand),
      .severe (sev)
    );

    always_comb begin
      if (!has)     kind = SLOT_IDLE;
      else if (sev) kind = SLOT_HOLD;
      else          kind = SLOT_DATA;
    end

    always_comb begin
      case (kind)
        SLOT_DATA: begin
          val = cand;
          flg = 1'b1;
        end
        SLOT_HOLD: begin
          // move only odd wires now; even wires stay static, so this is safe
          val = (prev_ch[c] & ~odd_m) | (cand & odd_m);
          flg = 1'b0;
        end
        default: begin
          val = prev_ch[c];
          flg = 1'b0;
        end
      endcase
    end

    assign take     = (kind == SLOT_DATA);
    assign k[c+1]   = k[c] + HW'(take);
    assign ch_nxt[c]   = val;
    assign flag_nxt[c] = flg;
  end

  assign placed = k[N_CH];

endmodule

// File: rtl/xtb_bus_pack.sv
// Lays lane data, flags and shields onto the bus wires.
module xtb_bus_pack
  import xtb_pkg::*;
#(
  parameter int SEG_W  = 32,
  parameter int N_CH   = 4,
  localparam int BUS_W = SEG_W * N_CH + 2 * N_CH - 1
) (
  input  logic [N_CH-1:0][SEG_W-1:0] ch_q,
  input  logic [N_CH-1:0]            flag_q,
  output logic [BUS_W-1:0]           bus
);

  for (genvar c = 0; c < N_CH; c++) begin : g_lane
    localparam int LSB = lane_lsb(BUS_W, SEG_W, c);
    assign bus[LSB +: SEG_W] = ch_q[c];
    assign bus[LSB-1]        = flag_q[c];
    if (c < N_CH - 1) begin : g_shield
      assign bus[LSB-2] = 1'b0;
    end
  end

endmodule

// File: rtl/xtb_tx.sv
module xtb_tx
  import xtb_pkg::*;
#(
  parameter int SEG_W   = 32,
  parameter int N_CH    = 4,
  localparam int WORD_W = SEG_W * N_CH,
  localparam int BUS_W  = WORD_W + 2 * N_CH - 1,
  localparam int HW     = $clog2(N_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic [BUS_W-1:0]  bus_out
);

  logic [N_CH-1:0][SEG_W-1:0] seg_q, seg_in, ch_q, ch_nxt;
  logic [N_CH-1:0]            flag_q, flag_nxt;
  logic [HW-1:0]              head_q, placed;
  logic                       empty, accept;

  for (genvar s = 0; s < N_CH; s++) begin : g_split
    assign seg_in[s] = in_data[WORD_W-1-s*SEG_W -: SEG_W];
  end

  xtb_slot_alloc #(.SEG_W(SEG_W), .N_CH(N_CH)) u_alloc (
    .seg_q    (seg_q),
    .prev_ch  (ch_q),
    .head     (head_q),
    .ch_nxt   (ch_nxt),
    .flag_nxt (flag_nxt),
    .placed   (placed)
  );

  xtb_bus_pack #(.SEG_W(SEG_W), .N_CH(N_CH)) u_pack (
    .ch_q   (ch_q),
    .flag_q (flag_q),
    .bus    (bus_out)
  );

  assign empty    = (head_q == HW'(N_CH));
  assign in_ready = empty | ((head_q + placed) == HW'(N_CH));
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q   <= '0;
      flag_q <= '0;
      seg_q  <= '0;
      head_q <= HW'(N_CH);
    end else begin
      ch_q   <= ch_nxt;
      flag_q <= flag_nxt;
      if (accept) begin
        seg_q  <= seg_in;
        head_q <= '0;
      end else if (!empty) begin
        head_q <= head_q + placed;
      end
    end
  end

endmodule

// File: rtl/xtb_tx_chk.sv
module xtb_tx_chk
  import xtb_pkg::*;
#(
  parameter int SEG_W  = 32,
  parameter int N_CH   = 4,
  localparam int BUS_W = SEG_W * N_CH + 2 * N_CH - 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [BUS_W-1:0] bus_out
);

  logic [BUS_W-1:0] prev_q;
  logic [N_CH-1:0]  fl;
  logic             sev_now;
  logic [SEG_W-1:0] even_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= bus_out;
  end

  function automatic int step(input logic p, input logic n);
    if (p == n) return 0;
    return n ? 1 : -1;
  endfunction

  // independent load count: static neighbour 1, opposite neighbour 2
  always_comb begin
    sev_now = 1'b0;
    fl      = '0;
    for (int c = 0; c < N_CH; c++) begin
      int lsb;
      lsb   = lane_lsb(BUS_W, SEG_W, c);
      fl[c] = bus_out[lsb-1];
      for (int b = 0; b < SEG_W; b++) begin
        int me, lo, hi, load;
        me = step(prev_q[lsb+b], bus_out[lsb+b]);
        lo = 0;
        hi = 0;
        if (b > 0)         lo = step(prev_q[lsb+b-1], bus_out[lsb+b-1]);
        if (b < SEG_W - 1) hi = step(prev_q[lsb+b+1], bus_out[lsb+b+1]);
        load = 0;
        if (lo == 0) load = load + 1;
        else if (lo == -me) load = load + 2;
        if (hi == 0) load = load + 1;
        else if (hi == -me) load = load + 2;
        if (me != 0 && load >= 3) sev_now = 1'b1;
      end
    end
  end

  for (genvar b = 0; b < SEG_W; b++) begin : g_even
    assign even_m[b] = (b % 2 == 0);
  end

  // R5: no lane ever shows a severe coupling transition
  a_r5_no_severe: assert property (@(posedge clk) disable iff (!rst_n) !sev_now);

  // R8: an all-idle bus cycle while pending is followed by data
  a_r8_progress: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!in_ready) && (fl == '0)) |=> (fl != '0));

  // R9: ready stays high when nothing was offered
  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_ready) && !$past(in_valid)) |-> in_ready);

  for (genvar c = 0; c < N_CH; c++) begin : g_lane
    localparam int LSB = lane_lsb(BUS_W, SEG_W, c);
    // R6 and R4: an idle lane never moves its even-index wires
    a_r6_idle_even_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_out[LSB-1] |->
        (((bus_out[LSB +: SEG_W] ^ $past(bus_out[LSB +: SEG_W])) & even_m) == '0));
  end

endmodule

bind xtb_tx xtb_tx_chk #(.SEG_W(SEG_W), .N_CH(N_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .bus_out  (bus_out)
);

// File: tb/xtb_tx_tb.sv
`timescale 1ns/1ps
module xtb_tx_tb;

  localparam int BW = 135;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [127:0]  in_data = '0;
  logic [BW-1:0] bus_out;

  int errs  = 0;
  int total = 0;

  always #2 clk = ~clk;

  xtb_tx u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .bus_out  (bus_out)
  );

  // expected bus image: lanes 0..3, flags f[3]=lane0 .. f[0]=lane3
  function automatic logic [BW-1:0] pk(input logic [31:0] a, b, c, d,
                                       input logic [3:0] f);
    return {a, f[3], 1'b0, b, f[2], 1'b0, c, f[1], 1'b0, d, f[0]};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [BW-1:0] act, input logic [BW-1:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    tick();
    tick();
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    tick();
    chk("R1", "bus in reset", bus_out, '0);
    chk("R1", "ready in reset", BW'(in_ready), BW'(1));
    rst_n = 1'b1;
  endtask

  task automatic t_layout;
    do_reset();
    in_valid = 1'b1;
    in_data  = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 32'hC0FFEE00};
    tick();  // transfer edge
    in_valid = 1'b0;
    chk("R9", "ready with all segments placeable", BW'(in_ready), BW'(1));
    tick();
    chk("R2", "lane layout and R3 data flags", bus_out,
        pk(32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 32'hC0FFEE00, 4'hF));
    tick();
    chk("R4", "idle lanes hold data, flags low", bus_out,
        pk(32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 32'hC0FFEE00, 4'h0));
  endtask

  task automatic t_classes;
    do_reset();
    in_valid = 1'b1;
    in_data  = {32'h0000000C, 32'h00000004, 32'hFFFFFFFF, 32'hFFFFFFFF};
    tick();  // first word taken
    in_data  = {32'h00000030, 32'h00000008, 32'hFFFFFFFF, 32'h00000000};
    tick();  // second word taken back to back
    chk("R9", "back-to-back first word on bus", bus_out,
        pk(32'h0000000C, 32'h00000004, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'hF));
    chk("R9", "ready low with a segment left over", BW'(in_ready), BW'(0));
    in_data = {32'h01234567, 32'h0000000C, 32'h00000008, 32'h76543210};
    tick();  // ready was low: this word must not be taken
    chk("R5", "mild accepted, severe refused, R6 staged, R7 order", bus_out,
        pk(32'h00000030, 32'h0000000C, 32'h00000008, 32'hFFFFFFFF, 4'b1011));
    chk("R9", "ready back once leftover fits", BW'(in_ready), BW'(1));
    tick();  // held word taken now
    in_valid = 1'b0;
    chk("R7", "leftover sent from lane 0, R4 others idle", bus_out,
        pk(32'h00000000, 32'h0000000C, 32'h00000008, 32'hFFFFFFFF, 4'b1000));
    tick();
    chk("R9", "word held during back-pressure sent once", bus_out,
        pk(32'h01234567, 32'h0000000C, 32'h00000008, 32'h76543210, 4'hF));
  endtask

  task automatic t_full_block;
    do_reset();
    in_valid = 1'b1;
    in_data  = {4{32'h55555555}};
    tick();
    in_data  = {4{32'hAAAAAAAA}};
    tick();
    in_valid = 1'b0;
    chk("R2", "alternating pattern on bus", bus_out,
        pk(32'h55555555, 32'h55555555, 32'h55555555, 32'h55555555, 4'hF));
    chk("R9", "ready low when every lane refuses", BW'(in_ready), BW'(0));
    tick();
    chk("R6", "all lanes staged idle", bus_out,
        pk(32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'h0));
    chk("R8", "ready after staging", BW'(in_ready), BW'(1));
    tick();
    chk("R8", "progress after an empty cycle", bus_out,
        pk(32'hAAAAAAAA, 32'hAAAAAAAA, 32'hAAAAAAAA, 32'hAAAAAAAA, 4'hF));
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    total++;
    $display("FAIL R8 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_layout();
    t_classes();
    t_full_block();
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

endmodule